// File: doc/BRIEF.md
# User RAM Clear Sequencer

This block keeps a small battery-backed user memory of 242 bytes and can wipe it to zero when an external, active-low clear line is pulled down. The wipe only happens if software has armed it through a clear-enable bit in an 8-bit control register. The clear line is asynchronous to the block clock. It is synchronized first, and a wipe starts on its falling edge.

While a wipe runs, the sequencer owns the memory port. It writes one zero byte per clock from address 0 up to the last address. Host writes are locked out and further clear requests are dropped. When the last byte has been written, a sticky completion flag is raised. If the interrupt-enable bit is set, an active-low interrupt line follows the flag. The host clears the flag with a one-cycle acknowledge pulse, and that also releases the interrupt.

The sequencer has three states. `ST_IDLE` waits for an armed falling edge and moves to `ST_WIPE` (transition *start*). `ST_WIPE` writes one byte per cycle. At the last address it moves to `ST_DONE` (transition *last*). `ST_DONE` lasts one cycle, sets the completion flag and returns to `ST_IDLE` (transition *finish*).

Top module: `ram_clear_seq`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0, `irq_n` is 1 and `ctrl_rdata` is 0x00.
- R2: When `busy` is 0, a host write with `ram_addr` below 242 stores `ram_wdata`, and `ram_rdata` returns the stored byte for that address. Writes to addresses 242 to 255 are dropped, and reads from those addresses return 0x00.
- R3: A wipe starts only on a falling edge of `clr_n` while control bit 4 (clear enable) is 1. `busy` first reads 1 after the third rising clock edge that follows `clr_n` going low.
- R4: With control bit 4 at 0, any activity on `clr_n` is ignored, whatever the other control bits hold: `busy` stays 0, `done` stays 0 and the memory contents are unchanged.
- R5: A wipe writes one byte per cycle, starting at address 0. `busy` stays high for exactly 242 cycles, and afterwards every byte reads 0x00.
- R6: Host writes presented while `busy` is 1 have no effect on the memory.
- R7: Holding `clr_n` low after a wipe does not start another wipe. A new falling edge that arrives while `busy` is 1 is dropped and does not lengthen or repeat the wipe.
- R8: `done` rises one cycle after `busy` falls. It then stays 1 until a cycle with `done_ack` high clears it.
- R9: `irq_n` is 0 exactly when `done` is 1 and control bit 2 (interrupt enable) is 1. Setting or clearing bit 2 while `done` is 1 takes effect on `irq_n` in the next cycle.
- R10: A write with `ctrl_we` high loads all eight bits of `ctrl_wdata`, and `ctrl_rdata` reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| clr_n | input | 1 | Active-low asynchronous clear request |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data (bit 4 clear enable, bit 2 interrupt enable) |
| ctrl_rdata | output | 8 | Control register readback |
| ram_we | input | 1 | Host memory write strobe |
| ram_addr | input | 8 | Host memory address, for both read and write |
| ram_wdata | input | 8 | Host memory write data |
| ram_rdata | output | 8 | Host memory read data (not valid while busy) |
| done_ack | input | 1 | One-cycle acknowledge that clears the completion flag |
| busy | output | 1 | Wipe in progress |
| done | output | 1 | Sticky completion flag |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
The assertions assume that the clear line settles before the synchronizer samples it. They also assume that the acknowledge is not pulsed in the same cycle that `ST_DONE` raises the flag. If it were, the set would win, and that case is not exercised. The bench therefore changes `clr_n` and every host input only on falling clock edges. It pulses `done_ack` only after `done` has been observed high. The toggle on `clr_n` inside a running wipe is placed well before the last address, so the dropped edge reaches the synchronizer output while `busy` is still 1.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIPE = 2'd1,
        ST_DONE = 2'd2
    } wipe_state_t;

    localparam int CTRL_W  = 8;
    localparam int BIT_RCE = 4;
    localparam int BIT_RIE = 2;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_pulse
);
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= async_in;
    end

    for (genvar gi = 1; gi <= STAGES; gi++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= 1'b1;
            else        chain[gi] <= chain[gi-1];
        end
    end

    assign fall_pulse = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
    import rcs_pkg::*;
#(
    parameter int DEPTH  = 242,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              busy,
    output logic              wipe_we,
    output logic [ADDR_W-1:0] wipe_addr,
    output logic              done_set
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    wipe_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req)           state_d = ST_WIPE;
            ST_WIPE: if (addr_q == LAST_ADDR) state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  addr_q <= '0;
        else if (state_q == ST_WIPE) addr_q <= addr_q + 1'b1;
        else                         addr_q <= '0;
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        wipe_we  = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WIPE: begin
                busy    = 1'b1;
                wipe_we = 1'b1;
            end
            ST_DONE: done_set = 1'b1;
            default: ;
        endcase
    end

    assign wipe_addr = addr_q;
endmodule

// File: rtl/rcs_ram.sv
module rcs_ram #(
    parameter int DEPTH  = 242,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              in_range;

    assign in_range = (addr <= LAST_ADDR);

    always_ff @(posedge clk) begin
        if (we && in_range) mem[addr] <= wdata;
    end

    assign rdata = in_range ? mem[addr] : '0;
endmodule

// File: rtl/ram_clear_seq.sv
module ram_clear_seq
    import rcs_pkg::*;
#(
    parameter int DEPTH       = 242,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] ram_rdata,
    input  logic              done_ack,
    output logic              busy,
    output logic              done,
    output logic              irq_n
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              clr_en;
    logic              irq_en;
    logic              clr_fall;
    logic              start_req;
    logic              wipe_we;
    logic [ADDR_W-1:0] wipe_addr;
    logic              done_set;
    logic              done_flag;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    assign clr_en     = ctrl_q[BIT_RCE];
    assign irq_en     = ctrl_q[BIT_RIE];
    assign ctrl_rdata = ctrl_q;

    rcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (clr_n),
        .fall_pulse(clr_fall)
    );

    assign start_req = clr_fall & clr_en;

    rcs_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .busy     (busy),
        .wipe_we  (wipe_we),
        .wipe_addr(wipe_addr),
        .done_set (done_set)
    );

    // memory port: sequencer owns it while busy
    always_comb begin
        if (busy) begin
            mem_we    = wipe_we;
            mem_addr  = wipe_addr;
            mem_wdata = '0;
        end else begin
            mem_we    = ram_we;
            mem_addr  = ram_addr;
            mem_wdata = ram_wdata;
        end
    end

    rcs_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(ram_rdata)
    );

    // sticky completion flag, set has priority over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (done_set) done_flag <= 1'b1;
        else if (done_ack) done_flag <= 1'b0;
    end

    assign done  = done_flag;
    assign irq_n = ~(done_flag & irq_en);
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int DEPTH  = 242,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done_flag,
    input logic              done_ack,
    input logic              irq_n,
    input logic              clr_en,
    input logic [ADDR_W-1:0] wipe_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(clr_en)); // R3
    AST_WIPE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> wipe_addr == '0); // R5
    AST_BUSY_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_cnt == CNT_W'(DEPTH)); // R5
    AST_WIPE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) busy && mem_we |-> mem_wdata == '0); // R6
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run_cnt < CNT_W'(DEPTH)); // R7
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |=> done_flag); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_flag && !done_ack |=> done_flag); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done_flag |-> irq_n); // R9
endmodule

bind ram_clear_seq rcs_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done_flag(done_flag),
    .done_ack (done_ack),
    .irq_n    (irq_n),
    .clr_en   (clr_en),
    .wipe_addr(wipe_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
);

// File: tb/tb_ram_clear_seq.sv
module tb_ram_clear_seq;
    localparam int DEPTH = 242;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       ram_we = 1'b0;
    logic [7:0] ram_addr = '0;
    logic [7:0] ram_wdata = '0;
    logic [7:0] ram_rdata;
    logic       done_ack = 1'b0;
    logic       busy, done, irq_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ram_clear_seq dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .done_ack(done_ack), .busy(busy), .done(done), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 7 + seed) & 8'hff);
    endfunction

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_ram(input int a, input logic [7:0] v);
        @(negedge clk);
        ram_we = 1'b1; ram_addr = 8'(a); ram_wdata = v;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < 256; a++) wr_ram(a, pat(a, seed));
    endtask

    task automatic sweep(input int seed, input bit zero, input string req);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            ram_addr = 8'(a);
            #1;
            if (a >= DEPTH)  check(ram_rdata == 8'h00, "R2", ram_rdata, 0);
            else if (zero)   check(ram_rdata == 8'h00, req, ram_rdata, 0);
            else             check(ram_rdata == pat(a, seed), req, ram_rdata, pat(a, seed));
        end
    endtask

    task automatic ack_done();
        @(negedge clk);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        check(done == 1'b0, "R8 ack clears", done, 0);
        check(irq_n == 1'b1, "R9 release", irq_n, 1);
    endtask

    // drive clr_n low, check start latency and run length
    task automatic run_wipe(input bit toggle);
        int cnt;
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R3 latency early", busy, 0);
        @(negedge clk);
        check(busy == 1'b1, "R3 latency start", busy, 1);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (cnt == 100) begin
                ram_we = 1'b1; ram_addr = 8'd5; ram_wdata = 8'hA5;
            end else begin
                ram_we = 1'b0;
            end
            if (toggle && cnt == 40) clr_n = 1'b1;
            if (toggle && cnt == 60) clr_n = 1'b0;
            @(negedge clk);
        end
        ram_we = 1'b0;
        check(cnt == DEPTH, "R5 busy length", cnt, DEPTH);
        check(done == 1'b0, "R8 done delay", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done set", done, 1);
    endtask

    task automatic hold_low(input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        check(seen == 1'b0, "R7 no restart", seen, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        check(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 0);
        rst_n = 1'b1;

        // R10 control readback
        wr_ctrl(8'h5A);
        check(ctrl_rdata == 8'h5A, "R10 readback", ctrl_rdata, 8'h5A);

        // R2 host access
        fill(3);
        sweep(3, 1'b0, "R2");

        // R4 every bit set except clear enable
        wr_ctrl(8'hEF);
        check(ctrl_rdata == 8'hEF, "R10 readback", ctrl_rdata, 8'hEF);
        @(negedge clk);
        clr_n = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (busy) seen = 1'b1;
                if (i == 5) clr_n = 1'b1;
                if (i == 10) clr_n = 1'b0;
            end
            check(seen == 1'b0, "R4 no busy", seen, 0);
        end
        clr_n = 1'b1;
        check(done == 1'b0, "R4 no done", done, 0);
        check(irq_n == 1'b1, "R4 no irq", irq_n, 1);
        sweep(3, 1'b0, "R4");

        // wipe with interrupt disabled, blocked host write at addr 5
        wr_ctrl(8'h10);
        run_wipe(1'b0);
        check(irq_n == 1'b1, "R9 masked", irq_n, 1);
        sweep(0, 1'b1, "R5/R6");
        hold_low(300);
        check(done == 1'b1, "R8 sticky", done, 1);
        wr_ctrl(8'h14);
        check(irq_n == 1'b0, "R9 enable late", irq_n, 0);
        wr_ctrl(8'h10);
        check(irq_n == 1'b1, "R9 disable late", irq_n, 1);
        wr_ctrl(8'h14);
        ack_done();

        // second wipe with a dropped falling edge mid-run
        @(negedge clk);
        clr_n = 1'b1;
        fill(11);
        sweep(11, 1'b0, "R2");
        run_wipe(1'b1);
        check(irq_n == 1'b0, "R9 asserted", irq_n, 0);
        hold_low(300);
        sweep(0, 1'b1, "R5/R7");
        ack_done();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule